// File: doc/BRIEF.md
# Branch Condition and Counter Unit

This block decides conditional branches for a processor front end. Each branch arrives as a one-cycle strobe with three inputs: a 5-bit options field, one condition bit already selected from the condition register, and the count register held inside the block. The options field decides two things. First, whether the count register is decremented. Second, how a test of the new count against zero is combined with a test of the condition bit for true or false.

One cycle after the strobe the block presents the taken or not-taken decision and a valid flag. At the same edge the updated count becomes visible. A separate load port writes the count register directly. The prediction hint bit of the options field is passed through unchanged.

Top module: `brcnt_unit`

## Requirements
- R1: While reset is asserted and after it is released with no activity, `cnt_q` is zero and `taken_q`, `done_q` and `hint_q` are all low.
- R2: `done_q` is high in exactly the cycle after a cycle with `br_valid` high. `taken_q` is low whenever `done_q` is low.
- R3: Bits are numbered with `br_opts[4]` as the leftmost character of a 5-character option pattern. When `br_opts[2]` is 0, a strobe decrements the counter by one. When `br_opts[2]` is 1, the counter is left unchanged.
- R4: On a decrementing strobe, the zero test uses the count after the decrement. With `br_opts[1]` = 0 the branch needs the new count to be nonzero; with `br_opts[1]` = 1 it needs the new count to be zero.
- R5: With `br_opts[4]` = 0, the branch needs `cond_bit` to equal `br_opts[3]` (0 means branch on false, 1 means branch on true). With `br_opts[4]` = 1, `cond_bit` and `br_opts[3]` have no effect.
- R6: With `br_opts[4]` = 1 and `br_opts[2]` = 1, the branch is always taken and the counter does not change.
- R7: Decrementing a counter of zero wraps it to all ones. That new count is nonzero for the zero test.
- R8: `ld_en` without a strobe makes `cnt_q` equal `ld_val` in the next cycle.
- R9: When `ld_en` and a decrementing strobe fall in the same cycle, the counter takes `ld_val`. The decision is still made from the counter value before the load.
- R10: `hint_q` carries `br_opts[0]` of the strobe. That bit never changes `taken_q`.
- R11: With neither a strobe nor a load, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| br_valid | input | 1 | Branch strobe, one cycle per branch |
| br_opts | input | 5 | Branch options field |
| cond_bit | input | 1 | Selected condition bit |
| ld_en | input | 1 | Count register load enable |
| ld_val | input | CNT_W | Value to load into the count register |
| taken_q | output | 1 | Branch decision, valid with done_q |
| done_q | output | 1 | Decision valid, one cycle after the strobe |
| hint_q | output | 1 | Prediction hint passed through from the strobe |
| cnt_q | output | CNT_W | Current count register |

## Verification
The bench builds the block with `CNT_W` = 8 and `EARLY_ZERO` = 1. The narrow counter makes the wrap from zero to all ones (R7) easy to reach. It also lets the zero test be hit from small loaded counts within a few strobes. The early zero detector compares the old count with one instead of testing the difference, so this build checks that variant against a reference model that subtracts first. The default build keeps 32 bits and the subtract-then-test path, which the default elaboration exercises.

// File: rtl/brcnt_pkg.sv
package brcnt_pkg;
   localparam int OPT_W = 5;

   typedef struct packed {
      logic dec_en;
      logic use_cond;
      logic cond_sense;
      logic zero_sense;
      logic hint;
   } brcnt_ctl_t;
endpackage

// File: rtl/brcnt_decode.sv
module brcnt_decode
   import brcnt_pkg::*;
(
   input  logic [OPT_W-1:0] opts,
   output brcnt_ctl_t       ctl
);
   always_comb begin
      ctl.dec_en     = ~opts[2];
      ctl.use_cond   = ~opts[4];
      ctl.cond_sense = opts[3];
      ctl.zero_sense = opts[1];
      ctl.hint       = opts[0];
   end
endmodule

// File: rtl/brcnt_counter.sv
module brcnt_counter #(
   parameter int CNT_W      = 32,
   parameter int EARLY_ZERO = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             dec_go,
   output logic [CNT_W-1:0] cnt,
   output logic             dec_zero
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_dec;

   assign cnt_dec = cnt - ONE;

   // Zero test of the post-decrement value; two equivalent forms
   generate
      if (EARLY_ZERO != 0) begin : g_early
         assign dec_zero = (cnt == ONE);
      end else begin : g_late
         assign dec_zero = (cnt_dec == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (ld_en)
         cnt <= ld_val;
      else if (dec_go)
         cnt <= cnt_dec;
   end
endmodule

// File: rtl/brcnt_resolve.sv
module brcnt_resolve (
   input  logic dec_en,
   input  logic use_cond,
   input  logic cond_sense,
   input  logic zero_sense,
   input  logic cond_bit,
   input  logic dec_zero,
   output logic take
);
   logic ctr_ok;
   logic cond_ok;

   always_comb begin
      ctr_ok  = ~dec_en | (dec_zero == zero_sense);
      cond_ok = ~use_cond | (cond_bit == cond_sense);
      take    = ctr_ok & cond_ok;
   end
endmodule

// File: rtl/brcnt_unit.sv
module brcnt_unit
   import brcnt_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int EARLY_ZERO = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             br_valid,
   input  logic [4:0]       br_opts,
   input  logic             cond_bit,
   input  logic             ld_en,
   input  logic [CNT_W-1:0] ld_val,
   output logic             taken_q,
   output logic             done_q,
   output logic             hint_q,
   output logic [CNT_W-1:0] cnt_q
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("brcnt_unit: CNT_W must be at least 2");
      end
      if (EARLY_ZERO != 0 && EARLY_ZERO != 1) begin : g_bad_zero
         $error("brcnt_unit: EARLY_ZERO must be 0 or 1");
      end
      if (OPT_W != 5) begin : g_bad_opts
         $error("brcnt_unit: options field must be 5 bits");
      end
   endgenerate

   brcnt_ctl_t ctl;
   logic       dec_zero;
   logic       take;
   logic       dec_go;

   brcnt_decode u_decode (
      .opts (br_opts),
      .ctl  (ctl)
   );

   assign dec_go = br_valid & ctl.dec_en;

   brcnt_counter #(
      .CNT_W      (CNT_W),
      .EARLY_ZERO (EARLY_ZERO)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_val   (ld_val),
      .dec_go   (dec_go),
      .cnt      (cnt_q),
      .dec_zero (dec_zero)
   );

   brcnt_resolve u_resolve (
      .dec_en     (ctl.dec_en),
      .use_cond   (ctl.use_cond),
      .cond_sense (ctl.cond_sense),
      .zero_sense (ctl.zero_sense),
      .cond_bit   (cond_bit),
      .dec_zero   (dec_zero),
      .take       (take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         taken_q <= 1'b0;
         hint_q  <= 1'b0;
      end else begin
         done_q  <= br_valid;
         taken_q <= br_valid & take;
         hint_q  <= br_valid & ctl.hint;
      end
   end
endmodule

// File: rtl/brcnt_unit_chk.sv
module brcnt_unit_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             br_valid,
   input logic [4:0]       br_opts,
   input logic             ld_en,
   input logic [CNT_W-1:0] ld_val,
   input logic             taken_q,
   input logic             done_q,
   input logic             hint_q,
   input logic [CNT_W-1:0] cnt_q
);
   // R2: valid flag follows the strobe by one cycle
   a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |=> done_q);
   a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !br_valid |=> !done_q);
   a_r2_taken_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> !taken_q);

   // R3: decrement by one, or hold
   a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !ld_en && !br_opts[2]) |=> cnt_q == $past(cnt_q) - 1'b1);
   a_r3_no_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !ld_en && br_opts[2]) |=> $stable(cnt_q));

   // R6: unconditional branch
   a_r6_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_opts[4] && br_opts[2]) |=> taken_q);

   // R8 / R9: load wins
   a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> cnt_q == $past(ld_val));

   // R10: hint pass-through
   a_r10_hint: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |=> hint_q == $past(br_opts[0]));

   // R11: idle hold
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!br_valid && !ld_en) |=> $stable(cnt_q));
endmodule

bind brcnt_unit brcnt_unit_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .br_valid (br_valid),
   .br_opts  (br_opts),
   .ld_en    (ld_en),
   .ld_val   (ld_val),
   .taken_q  (taken_q),
   .done_q   (done_q),
   .hint_q   (hint_q),
   .cnt_q    (cnt_q)
);

// File: tb/brcnt_unit_bench.sv
`timescale 1ns/1ps
module brcnt_unit_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         br_valid = 1'b0;
   logic [4:0]   br_opts = '0;
   logic         cond_bit = 1'b0;
   logic         ld_en = 1'b0;
   logic [W-1:0] ld_val = '0;
   logic         taken_q, done_q, hint_q;
   logic [W-1:0] cnt_q;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   // Reference state
   int m_cnt = 0;

   always #4 clk = ~clk;

   brcnt_unit #(.CNT_W(W), .EARLY_ZERO(1)) u_brcnt_unit (
      .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_opts(br_opts),
      .cond_bit(cond_bit), .ld_en(ld_en), .ld_val(ld_val),
      .taken_q(taken_q), .done_q(done_q), .hint_q(hint_q), .cnt_q(cnt_q)
   );

   task automatic check(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One clock: drive at a falling edge, compare at the next falling edge
   task automatic step(string req, bit v, bit [4:0] o, bit c, bit l, int lv);
      bit exp_take;
      int next_cnt;
      bit dec;
      bit ctr_ok;
      bit cond_ok;
      br_valid = v; br_opts = o; cond_bit = c; ld_en = l; ld_val = W'(lv);
      // Expected values from the requirements
      dec      = v && (o[2] == 1'b0);
      next_cnt = dec ? (m_cnt + (1 << W) - 1) % (1 << W) : m_cnt;
      ctr_ok   = !dec || ((next_cnt == 0) == o[1]);
      cond_ok  = o[4] || (c == o[3]);
      exp_take = v && ctr_ok && cond_ok;
      m_cnt    = l ? (lv % (1 << W)) : next_cnt;
      @(negedge clk);
      check(req, int'(done_q),  int'(v),        "done_q");
      check(req, int'(taken_q), int'(exp_take), "taken_q");
      check(req, int'(hint_q),  int'(v && o[0]), "hint_q");
      check(req, int'(cnt_q),   m_cnt,          "cnt_q");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", int'(cnt_q), 0, "cnt_q in reset");
      check("R1", int'(taken_q) + int'(done_q) + int'(hint_q), 0, "flags in reset");
      rst_n = 1'b1;
      step("R1", 0, 5'b00000, 0, 0, 0);
      step("R8", 0, 5'b00000, 0, 1, 3);
      step("R4", 1, 5'b00000, 0, 0, 0);   // 3->2 nonzero, cond false: taken
      step("R4", 1, 5'b00010, 0, 0, 0);   // 2->1 not zero: not taken
      step("R4", 1, 5'b00010, 0, 0, 0);   // 1->0 zero: taken
      step("R7", 1, 5'b00000, 0, 0, 0);   // 0 wraps to 255, nonzero: taken
      step("R7", 0, 5'b00000, 0, 0, 0);
      step("R5", 1, 5'b00100, 0, 0, 0);   // branch on false, cond 0: taken
      step("R5", 1, 5'b00110, 1, 0, 0);   // branch on false, cond 1: not taken
      step("R3", 1, 5'b01100, 1, 0, 0);   // branch on true, no decrement
      step("R5", 1, 5'b01111, 0, 0, 0);   // branch on true, cond 0: not taken
      step("R8", 0, 5'b00000, 0, 1, 1);
      step("R5", 1, 5'b01010, 1, 0, 0);   // 1->0 zero, cond true: taken
      step("R5", 1, 5'b01000, 0, 0, 0);   // cond false blocks
      step("R5", 1, 5'b10000, 0, 0, 0);   // condition ignored
      step("R5", 1, 5'b11000, 1, 0, 0);   // z bit set, condition ignored
      step("R6", 1, 5'b10100, 0, 0, 0);
      step("R6", 1, 5'b11111, 1, 0, 0);
      step("R10", 1, 5'b00001, 0, 0, 0);
      step("R10", 1, 5'b00000, 0, 0, 0);
      step("R11", 0, 5'b11111, 1, 0, 0);
      step("R11", 0, 5'b00000, 0, 0, 0);
      step("R8", 0, 5'b00000, 0, 1, 2);
      step("R9", 1, 5'b00010, 0, 1, 9);   // 2->1 not zero, load 9 wins
      step("R9", 1, 5'b10010, 0, 1, 5);   // 9->8 not zero: not taken, load 5
      step("R8", 0, 5'b00000, 0, 1, 1);
      step("R9", 1, 5'b10010, 0, 1, 0);   // 1->0 zero: taken, load 0
      step("R2", 0, 5'b10100, 0, 0, 0);
      for (int i = 0; i < 400; i++) begin
         bit [31:0] r = $urandom;
         step("R2", r[0] | r[1], r[6:2], r[7], (r[11:8] == 0), int'(r[19:12]) % 4);
      end
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule